// File: doc/BRIEF.md
# Memory-Mapped Register Block with Interrupt Aggregation

This block is the 32-bit register front end of a small peripheral. It sits on a simple register bus that runs one access per cycle. Each access carries an address, write data, an access size in bytes, and separate read and write strobes. The block returns read data one clock after the read strobe is sampled.

The block holds three things:
- a constant identification word;
- a check register, which stores the inverse of each word written to it so that software can confirm the bus path is alive;
- an interrupt status word.

Software can set bits in the status word through one address and clear them through another. Two internal engines also raise fixed status bits with single-cycle pulses: a compute engine and a transfer engine. A single level-sensitive interrupt line is high whenever any status bit is set.

Accesses are checked in two ways. A read of the wrong size, or of an address that no register decodes, returns all ones. A write of the wrong size in the low register window is dropped. The compute and transfer datapaths are not part of this block; it only provides their interrupt bits.

Top module: `mmio_irq_regs`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED; writes to 0x00 leave that value unchanged.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the write data, and a 4-byte read of 0x04 returns the stored value.
- R3: A 4-byte read of offset 0x24 returns the current interrupt status word.
- R4: A 4-byte write to offset 0x60 ORs the write data into the status word.
- R5: A 4-byte write to offset 0x64 clears every status bit that is set in the write data.
- R6: The interrupt output is registered. It is high one cycle after the status word becomes nonzero, and low one cycle after the status word becomes zero.
- R7: A one-cycle pulse on `cmp_done` sets status bit 0 (0x00000001); a pulse on `xfr_done` sets status bit 8 (0x00000100).
- R8: A read whose size is not 4 bytes returns 0xFFFFFFFF, whatever the address.
- R9: A write below offset 0x80 whose size is not 4 bytes changes no register.
- R10: A 4-byte read of an offset that no readable register decodes (for example 0x08 or 0x60) returns 0xFFFFFFFF.
- R11: When engine pulses and a bus clear write fall in the same cycle, the set bits are ORed in first and the clear mask is applied last. Clear therefore wins on a shared bit.
- R12: Reset clears the check register, the status word, the read data and the interrupt output.
- R13: The read data register is loaded only on a cycle with the read strobe high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (20) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_size | input | SIZE_W (4) | Access size in bytes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after the read strobe |
| cmp_done | input | 1 | Compute-engine done pulse, raises status bit 0 |
| xfr_done | input | 1 | Transfer-engine done pulse, raises status bit 8 |
| irq_out | output | 1 | Level interrupt, high while status is nonzero |

## Verification
Register writes and engine pulses take effect at the first rising edge that samples them. Read data is due on the following edge. The interrupt line follows the status word one further edge later.

The bench drives every input on a falling edge. It samples read data on the next falling edge, half a cycle after the capturing edge. It checks the interrupt line on two consecutive falling edges after a status change: first still at its old level, then at the new one. In this way the extra register stage is pinned down exactly, not merely tolerated.

// File: rtl/mmio_regs_pkg.sv
package mmio_regs_pkg;
   localparam logic [31:0] ID_WORD     = 32'h0100_00ED;
   localparam int          OFS_ID      = 'h00;
   localparam int          OFS_CHK     = 'h04;
   localparam int          OFS_STAT    = 'h24;
   localparam int          OFS_SET     = 'h60;
   localparam int          OFS_CLR     = 'h64;
   localparam int          WIDE_BASE   = 'h80;
   localparam int          WORD_BYTES  = 4;
   localparam int          DWORD_BYTES = 8;
   localparam int          CMP_BIT     = 0;
   localparam int          XFR_BIT     = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_CHK,
      SEL_STAT,
      SEL_SET,
      SEL_CLR
   } reg_sel_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
   import mmio_regs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic              rd,
   input  logic              wr,
   output reg_sel_e          sel,
   output logic              rd_ok,
   output logic              wr_ok
);
   localparam logic [SIZE_W-1:0] SZ_WORD  = SIZE_W'(WORD_BYTES);
   localparam logic [SIZE_W-1:0] SZ_DWORD = SIZE_W'(DWORD_BYTES);
   localparam logic [ADDR_W-1:0] A_WIDE   = ADDR_W'(WIDE_BASE);

   logic low_win;

   always_comb begin
      unique case (addr)
         ADDR_W'(OFS_ID):   sel = SEL_ID;
         ADDR_W'(OFS_CHK):  sel = SEL_CHK;
         ADDR_W'(OFS_STAT): sel = SEL_STAT;
         ADDR_W'(OFS_SET):  sel = SEL_SET;
         ADDR_W'(OFS_CLR):  sel = SEL_CLR;
         default:           sel = SEL_NONE;
      endcase
   end

   assign low_win = (addr < A_WIDE);
   assign rd_ok   = rd && (size == SZ_WORD);
   assign wr_ok   = wr && (low_win ? (size == SZ_WORD)
                                   : ((size == SZ_WORD) || (size == SZ_DWORD)));
endmodule

// File: rtl/mmio_chk_reg.sv
module mmio_chk_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= ~wdata;
   end
endmodule

// File: rtl/mmio_irq_agg.sv
module mmio_irq_agg #(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   input  logic [DATA_W-1:0] raise_vec,
   output logic [DATA_W-1:0] stat_q,
   output logic              irq
);
   logic [DATA_W-1:0] stat_d;
   logic              any_set;

   // set first, clear last: clear wins on a shared bit
   assign stat_d  = (stat_q | set_mask | raise_vec) & ~clr_mask;
   assign any_set = |stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_set;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = any_set;
      end
   endgenerate
endmodule

// File: rtl/mmio_irq_regs.sv
module mmio_irq_regs
   import mmio_regs_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [SIZE_W-1:0] bus_size,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmp_done,
   input  logic              xfr_done,
   output logic              irq_out
);
   localparam int N_SRC = 2;
   localparam int SRC_POS [N_SRC] = '{CMP_BIT, XFR_BIT};

   initial begin
      if (DATA_W != 32)      $error("DATA_W must be 32");
      if (ADDR_W < 8)        $error("ADDR_W too small for the register window");
      if (SIZE_W < 4)        $error("SIZE_W must encode a size of 8");
      if (XFR_BIT >= DATA_W) $error("raise bit outside status word");
   end

   reg_sel_e          sel;
   logic              rd_ok, wr_ok;
   logic              chk_we;
   logic [DATA_W-1:0] chk_q, stat_q;
   logic [DATA_W-1:0] set_mask, clr_mask, raise_vec;
   logic [DATA_W-1:0] rd_mux;
   logic [N_SRC-1:0]  src_pulse;

   mmio_addr_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dec (
      .addr  (bus_addr),
      .size  (bus_size),
      .rd    (bus_rd),
      .wr    (bus_wr),
      .sel   (sel),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok)
   );

   assign chk_we   = wr_ok && (sel == SEL_CHK);
   assign set_mask = (wr_ok && (sel == SEL_SET)) ? bus_wdata : '0;
   assign clr_mask = (wr_ok && (sel == SEL_CLR)) ? bus_wdata : '0;

   mmio_chk_reg #(.DATA_W(DATA_W)) u_chk (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (chk_we),
      .wdata (bus_wdata),
      .q     (chk_q)
   );

   assign src_pulse = {xfr_done, cmp_done};

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_raise_bit
         logic hit;
         always_comb begin
            hit = 1'b0;
            for (int s = 0; s < N_SRC; s++)
               if (SRC_POS[s] == b) hit = hit | src_pulse[s];
         end
         assign raise_vec[b] = hit;
      end
   endgenerate

   mmio_irq_agg #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (set_mask),
      .clr_mask  (clr_mask),
      .raise_vec (raise_vec),
      .stat_q    (stat_q),
      .irq       (irq_out)
   );

   always_comb begin
      rd_mux = '1;
      if (rd_ok) begin
         unique case (sel)
            SEL_ID:   rd_mux = DATA_W'(ID_WORD);
            SEL_CHK:  rd_mux = chk_q;
            SEL_STAT: rd_mux = stat_q;
            default:  rd_mux = '1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/mmio_irq_regs_chk.sv
module mmio_irq_regs_chk #(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [SIZE_W-1:0] bus_size,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cmp_done,
   input logic              xfr_done,
   input logic              irq_out,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] chk_q
);
   logic sz4, wr_id, wr_chk, wr_set, wr_clr, bad_wr, rd_id, bad_rd;

   assign sz4    = (bus_size == SIZE_W'(4));
   assign wr_id  = bus_wr && sz4 && (bus_addr == ADDR_W'(32'h00));
   assign wr_chk = bus_wr && sz4 && (bus_addr == ADDR_W'(32'h04));
   assign wr_set = bus_wr && sz4 && (bus_addr == ADDR_W'(32'h60));
   assign wr_clr = bus_wr && sz4 && (bus_addr == ADDR_W'(32'h64));
   assign bad_wr = bus_wr && !sz4 && (bus_addr < ADDR_W'(32'h80));
   assign rd_id  = bus_rd && sz4 && (bus_addr == ADDR_W'(32'h00));
   assign bad_rd = bus_rd && !sz4;

   // R1
   a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
      rd_id |=> bus_rdata == DATA_W'(32'h0100_00ED));
   // R1: a write to the ID offset touches no register
   a_r1_id_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_id && !cmp_done && !xfr_done |=> $stable(stat_q) && $stable(chk_q));
   // R2
   a_r2_chk_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_chk |=> chk_q == ~$past(bus_wdata));
   // R4
   a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (stat_q & $past(bus_wdata)) == $past(bus_wdata));
   // R5 and R11: clear is applied last
   a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (stat_q & $past(bus_wdata)) == '0);
   // R6
   a_r6_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != '0) |=> irq_out);
   a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == '0) |=> !irq_out);
   // R7
   a_r7_cmp_raise: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done && !wr_clr |=> stat_q[0]);
   a_r7_xfr_raise: assert property (@(posedge clk) disable iff (!rst_n)
      xfr_done && !wr_clr |=> stat_q[8]);
   // R8
   a_r8_bad_size_read: assert property (@(posedge clk) disable iff (!rst_n)
      bad_rd |=> bus_rdata == '1);
   // R9
   a_r9_bad_size_write: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr && !cmp_done && !xfr_done |=> $stable(stat_q) && $stable(chk_q));
   // R13
   a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind mmio_irq_regs mmio_irq_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .IRQ_REG(IRQ_REG)
) u_regs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_size  (bus_size),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .cmp_done  (cmp_done),
   .xfr_done  (xfr_done),
   .irq_out   (irq_out),
   .stat_q    (stat_q),
   .chk_q     (chk_q)
);

// File: tb/test_mmio_irq_regs.sv
module test_mmio_irq_regs;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 32;
   localparam int SIZE_W = 4;
   localparam int NVEC   = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [SIZE_W-1:0] bus_size = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic              cmp_done = 1'b0;
   logic              xfr_done = 1'b0;
   logic              irq_out;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   mmio_irq_regs i_mmio_irq_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_rdata(bus_rdata), .cmp_done(cmp_done), .xfr_done(xfr_done),
      .irq_out(irq_out)
   );

   // entry: {is_read, size, addr, wdata, expected, requirement number}
   localparam logic [80:0] VEC [NVEC] = '{
      {1'b1, 4'd4, 8'h00, 32'h0,         32'h0100_00ED, 4'd1},  // R1 ID
      {1'b0, 4'd4, 8'h00, 32'h1234_5678, 32'h0,         4'd1},  // R1 write ID
      {1'b1, 4'd4, 8'h00, 32'h0,         32'h0100_00ED, 4'd1},  // R1 unchanged
      {1'b0, 4'd4, 8'h04, 32'hA5A5_0F0F, 32'h0,         4'd2},  // R2
      {1'b1, 4'd4, 8'h04, 32'h0,         32'h5A5A_F0F0, 4'd2},  // R2 inverse
      {1'b0, 4'd2, 8'h04, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9 half write
      {1'b1, 4'd4, 8'h04, 32'h0,         32'h5A5A_F0F0, 4'd9},  // R9 unchanged
      {1'b1, 4'd2, 8'h04, 32'h0,         32'hFFFF_FFFF, 4'd8},  // R8
      {1'b1, 4'd1, 8'h00, 32'h0,         32'hFFFF_FFFF, 4'd8},  // R8
      {1'b1, 4'd8, 8'h24, 32'h0,         32'hFFFF_FFFF, 4'd8},  // R8
      {1'b1, 4'd4, 8'h08, 32'h0,         32'hFFFF_FFFF, 4'd10}, // R10
      {1'b1, 4'd4, 8'h60, 32'h0,         32'hFFFF_FFFF, 4'd10}, // R10
      {1'b0, 4'd4, 8'h60, 32'h0000_0301, 32'h0,         4'd4},  // R4
      {1'b1, 4'd4, 8'h24, 32'h0,         32'h0000_0301, 4'd3},  // R3
      {1'b0, 4'd4, 8'h64, 32'h0000_0300, 32'h0,         4'd5},  // R5
      {1'b1, 4'd4, 8'h24, 32'h0,         32'h0000_0001, 4'd5},  // R5
      {1'b0, 4'd1, 8'h60, 32'hF000_0000, 32'h0,         4'd9},  // R9 byte write
      {1'b1, 4'd4, 8'h24, 32'h0,         32'h0000_0001, 4'd9},  // R9 unchanged
      {1'b0, 4'd4, 8'h64, 32'h0000_0001, 32'h0,         4'd5},  // R5
      {1'b1, 4'd4, 8'h24, 32'h0,         32'h0000_0000, 4'd5}   // R5 empty
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz);
      @(negedge clk);
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [3:0] sz, output logic [31:0] d);
      @(negedge clk);
      bus_addr = ADDR_W'(a); bus_size = sz; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      check("R12 irq after reset", {31'b0, irq_out}, 32'h0);
      check("R12 rdata after reset", bus_rdata, 32'h0);
      bus_read(8'h04, 4'd4, rd); check("R12 check reg after reset", rd, 32'h0);
      bus_read(8'h24, 4'd4, rd); check("R12 status after reset", rd, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][80]) begin
            bus_read(VEC[i][75:68], VEC[i][79:76], rd);
            total++;
            if (rd !== VEC[i][35:4]) begin
               bad++;
               $display("FAIL R%0d vector %0d actual=%h expected=%h",
                        VEC[i][3:0], i, rd, VEC[i][35:4]);
            end
         end else begin
            bus_write(VEC[i][75:68], VEC[i][67:36], VEC[i][79:76]);
         end
      end

      // R13: rdata holds with no read strobe
      @(negedge clk); @(negedge clk);
      check("R13 rdata hold", bus_rdata, 32'h0);

      // R6: irq follows status one edge later
      bus_write(8'h60, 32'h0000_0010, 4'd4);
      check("R6 irq not yet high", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      check("R6 irq high", {31'b0, irq_out}, 32'h1);
      bus_write(8'h64, 32'h0000_0010, 4'd4);
      check("R6 irq not yet low", {31'b0, irq_out}, 32'h1);
      @(negedge clk);
      check("R6 irq low", {31'b0, irq_out}, 32'h0);

      // R7: engine pulses
      @(negedge clk); cmp_done = 1'b1;
      @(negedge clk); cmp_done = 1'b0;
      bus_read(8'h24, 4'd4, rd); check("R7 compute bit 0", rd, 32'h0000_0001);
      @(negedge clk); xfr_done = 1'b1;
      @(negedge clk); xfr_done = 1'b0;
      bus_read(8'h24, 4'd4, rd); check("R7 transfer bit 8", rd, 32'h0000_0101);
      check("R7 irq raised", {31'b0, irq_out}, 32'h1);

      // R11: clear wins over a same-cycle raise
      @(negedge clk);
      cmp_done = 1'b1; xfr_done = 1'b1;
      bus_addr = ADDR_W'(8'h64); bus_wdata = 32'h0000_0101; bus_size = 4'd4; bus_wr = 1'b1;
      @(negedge clk);
      cmp_done = 1'b0; xfr_done = 1'b0; bus_wr = 1'b0;
      bus_read(8'h24, 4'd4, rd); check("R11 clear wins", rd, 32'h0);
      @(negedge clk); cmp_done = 1'b1; xfr_done = 1'b1;
      bus_addr = ADDR_W'(8'h64); bus_wdata = 32'h0000_0001; bus_wr = 1'b1;
      @(negedge clk);
      cmp_done = 1'b0; xfr_done = 1'b0; bus_wr = 1'b0;
      bus_read(8'h24, 4'd4, rd); check("R11 merge keeps bit 8", rd, 32'h0000_0100);

      // R12: reset in mid-run
      @(negedge clk);
      check("R12 irq set before reset", {31'b0, irq_out}, 32'h1);
      rst_n = 1'b0;
      #1;
      check("R12 irq cleared by reset", {31'b0, irq_out}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      bus_read(8'h24, 4'd4, rd); check("R12 status cleared", rd, 32'h0);
      bus_read(8'h04, 4'd4, rd); check("R12 check reg cleared", rd, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule